// File: doc/BRIEF.md
# Hierarchical Interrupt Summary Register

This block gathers interrupt events for a cell-processing device with several port views into a small tree of clear-on-read registers. At the top of the tree is a summary register. It holds a latched one-second event bit and two summary bits. The summary bits report whether anything is pending in a transmit indication register or in a receive indication register. Each indication register has one bit per event line. A bit latches when its line falls from 1 to 0 and its enable bit is 1. A single level interrupt output is raised while any summary bit is set.

Software reads the summary register from any of the eight port views to find out which source fired. It then reads the indication register that the summary points to. That read returns the pending bits and clears them. Once the indication register is clear, its summary bit drops on its own. Reading the summary register clears only the one-second bit.

All event pins are asynchronous. Each pin passes through a two-stage synchronizer. An edge is found by comparing the newest synchronized sample with the one before it.

Top module: `irq_summary_unit`

## Requirements
- R1: A read of offset 0x00 returns the summary register. Bit 3 is the one-second event, bit 1 is the transmit summary and bit 0 is the receive summary. Bits 7..4 and bit 2 always read 0.
- R2: The read data appears in the cycle after the cycle in which the read strobe is sampled. The data is 0 in any cycle whose previous cycle had no strobe. A read of an unmapped offset returns 0 and clears nothing.
- R3: The one-second bit sets on every rising edge of `sec_pulse_i`. A pin change made before clock edge N is visible after edge N+2.
- R4: Any read of offset 0x00 clears the one-second bit. The address is formed as {port[2:0], offset[5:0]}, and the clear works the same from each of the eight port views.
- R5: Transmit indication bit i sets on a 1-to-0 transition of `tx_evt_i[i]` only while `tx_en_i[i]` is 1. Receive indication bit i follows the same rule with `rx_evt_i[i]` and `rx_en_i[i]`. A transition seen while the enable is 0 is dropped, even if the enable is set later.
- R6: A read of offset 0x2C returns the transmit indication bits and then clears them. A read of offset 0x2D does the same for the receive indication bits. Neither read touches the other register.
- R7: Summary bit 1 is set exactly while any transmit indication bit is pending. Summary bit 0 is set exactly while any receive indication bit is pending. Each summary bit returns to 0 after its indication register has been read.
- R8: A read of the summary register leaves both indication registers unchanged.
- R9: When an event sets a bit in the same cycle as a clearing read of that register, the read returns the old value and the new bit stays set.
- R10: `irq_o` is 1 exactly while at least one of summary bits 3, 1 or 0 is 1.
- R11: After reset, all pending bits are 0, `rd_data_o` is 0 and `irq_o` is 0. Pin levels held through reset do not create an event: a high one-second pin and high event lines are taken as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb_i | input | 1 | Read strobe |
| rd_addr_i | input | 9 | Read address {port view, register offset} |
| rd_data_o | output | 8 | Read data, one cycle after the strobe |
| sec_pulse_i | input | 1 | Asynchronous one-second pulse pin |
| tx_evt_i | input | 8 | Asynchronous transmit event lines, active on a fall |
| rx_evt_i | input | 8 | Asynchronous receive event lines, active on a fall |
| tx_en_i | input | 8 | Per-line enables for transmit events |
| rx_en_i | input | 8 | Per-line enables for receive events |
| irq_o | output | 1 | Level interrupt, OR of the summary bits |

## Verification
The hardest case to reach from the ports is an event that lands in the same clock edge as the read that clears its register. That event must survive while the read still returns the old value. The pin path has three register stages, so the bench times the collision by counting edges. It lowers an event line, waits exactly two cycles and then issues the clearing read. It then checks that the read returned 0 and that a second read finds the bit. A similar counted timing shows that an edge arriving while its enable is low is dropped for good, not held until the enable rises.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int DATA_W   = 8;
    localparam int OFF_W    = 6;
    localparam int PORT_W   = 3;
    localparam int ADDR_W   = PORT_W + OFF_W;

    localparam logic [OFF_W-1:0] OFF_SUMMARY = 6'h00;
    localparam logic [OFF_W-1:0] OFF_TX_IND  = 6'h2C;
    localparam logic [OFF_W-1:0] OFF_RX_IND  = 6'h2D;

    localparam int BIT_SEC = 3;
    localparam int BIT_TX  = 1;
    localparam int BIT_RX  = 0;

    localparam logic [DATA_W-1:0] SUMMARY_USED =
        DATA_W'((1 << BIT_SEC) | (1 << BIT_TX) | (1 << BIT_RX));

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SUMMARY,
        SEL_TX_IND,
        SEL_RX_IND
    } rd_sel_e;

    typedef struct packed {
        logic sec;
        logic tx;
        logic rx;
    } summary_t;

    function automatic rd_sel_e decode_offset(logic [OFF_W-1:0] off);
        rd_sel_e s;
        case (off)
            OFF_SUMMARY: s = SEL_SUMMARY;
            OFF_TX_IND:  s = SEL_TX_IND;
            OFF_RX_IND:  s = SEL_RX_IND;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_summary(summary_t s);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[BIT_SEC] = s.sec;
        w[BIT_TX]  = s.tx;
        w[BIT_RX]  = s.rx;
        return w;
    endfunction

endpackage

// File: rtl/isr_edge_det.sv
module isr_edge_det #(
    parameter int WIDTH = 1,
    parameter bit RISE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] edge_o
);
    // Reset to the level that follows the detected edge, so idle pins held
    // through reset never look like an event.
    localparam logic [WIDTH-1:0] IDLE_LVL = RISE ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= IDLE_LVL;
            sync_q <= IDLE_LVL;
            prev_q <= IDLE_LVL;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    generate
        if (RISE) begin : g_rise
            assign edge_o = sync_q & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sync_q & prev_q;
        end
    endgenerate

    // R3 / R5: an edge on a line lasts exactly one cycle.
    a_r5_edge_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (edge_o & $past(edge_o)) == '0);

endmodule

// File: rtl/isr_pend_reg.sv
module isr_pend_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] pend_q;

    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (clr_i ? '0 : pend_q) | set_i;
        end
    end

    assign pend_o = pend_q;

    // R9: every requested set is present on the next cycle, clear or not.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    // R6: a clear with no concurrent set empties the register.
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i == '0) |=> (pend_q == '0));

    // R5: without set or clear, nothing changes.
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && set_i == '0) |=> $stable(pend_q));

endmodule

// File: rtl/isr_rd_dec.sv
module isr_rd_dec
    import isr_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output rd_sel_e           sel_o
);
    logic [PORT_W-1:0] port;
    logic [OFF_W-1:0]  off;
    logic              port_ok;

    assign port    = rd_addr_i[ADDR_W-1:OFF_W];
    assign off     = rd_addr_i[OFF_W-1:0];
    assign port_ok = (32'(port) < NUM_PORTS);

    always_comb begin
        sel_o = SEL_NONE;
        if (rd_stb_i && port_ok) begin
            sel_o = decode_offset(off);
        end
    end

endmodule

// File: rtl/irq_summary_unit.sv
module irq_summary_unit
    import isr_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int IND_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_stb_i,
    input  logic [isr_pkg::ADDR_W-1:0] rd_addr_i,
    output logic [isr_pkg::DATA_W-1:0] rd_data_o,
    input  logic                      sec_pulse_i,
    input  logic [IND_W-1:0]          tx_evt_i,
    input  logic [IND_W-1:0]          rx_evt_i,
    input  logic [IND_W-1:0]          tx_en_i,
    input  logic [IND_W-1:0]          rx_en_i,
    output logic                      irq_o
);
    rd_sel_e           sel;
    logic [0:0]        sec_rise;
    logic [0:0]        sec_pend;
    logic [IND_W-1:0]  tx_fall, rx_fall;
    logic [IND_W-1:0]  tx_set, rx_set;
    logic [IND_W-1:0]  tx_pend, rx_pend;
    summary_t          summ;
    logic [DATA_W-1:0] tx_word, rx_word, rd_next;
    logic [DATA_W-1:0] rd_data_q;

    isr_rd_dec #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .rd_stb_i (rd_stb_i),
        .rd_addr_i(rd_addr_i),
        .sel_o    (sel)
    );

    isr_edge_det #(.WIDTH(1), .RISE(1'b1)) u_sec_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_i (sec_pulse_i),
        .edge_o(sec_rise)
    );

    isr_edge_det #(.WIDTH(IND_W), .RISE(1'b0)) u_tx_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_i (tx_evt_i),
        .edge_o(tx_fall)
    );

    isr_edge_det #(.WIDTH(IND_W), .RISE(1'b0)) u_rx_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_i (rx_evt_i),
        .edge_o(rx_fall)
    );

    assign tx_set = tx_fall & tx_en_i;
    assign rx_set = rx_fall & rx_en_i;

    isr_pend_reg #(.WIDTH(1)) u_sec_pend (
        .clk   (clk),
        .rst   (rst),
        .set_i (sec_rise),
        .clr_i (sel == SEL_SUMMARY),
        .pend_o(sec_pend)
    );

    isr_pend_reg #(.WIDTH(IND_W)) u_tx_pend (
        .clk   (clk),
        .rst   (rst),
        .set_i (tx_set),
        .clr_i (sel == SEL_TX_IND),
        .pend_o(tx_pend)
    );

    isr_pend_reg #(.WIDTH(IND_W)) u_rx_pend (
        .clk   (clk),
        .rst   (rst),
        .set_i (rx_set),
        .clr_i (sel == SEL_RX_IND),
        .pend_o(rx_pend)
    );

    assign summ.sec = sec_pend[0];
    assign summ.tx  = |tx_pend;
    assign summ.rx  = |rx_pend;

    always_comb begin
        tx_word            = '0;
        rx_word            = '0;
        tx_word[IND_W-1:0] = tx_pend;
        rx_word[IND_W-1:0] = rx_pend;
        case (sel)
            SEL_SUMMARY: rd_next = pack_summary(summ);
            SEL_TX_IND:  rd_next = tx_word;
            SEL_RX_IND:  rd_next = rx_word;
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_next;
        end
    end

    assign rd_data_o = rd_data_q;
    assign irq_o     = summ.sec | summ.tx | summ.rx;

    // R1: reserved bits of the summary word read as zero.
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_SUMMARY) |=> ((rd_data_o & ~SUMMARY_USED) == '0));

    // R2: no strobe, no data.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_i |=> (rd_data_o == '0));

    // R4: a summary read clears the one-second bit unless a new edge arrives.
    a_r4_sec_cleared: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_SUMMARY && sec_rise == 1'b0) |=> (sec_pend == 1'b0));

    // R5: a newly set transmit bit had its enable high.
    a_r5_tx_enable_gate: assert property (@(posedge clk) disable iff (rst)
        (tx_pend & ~$past(tx_pend) & ~$past(tx_en_i)) == '0);

    // R8: a summary read keeps the indication bits.
    a_r8_summary_keeps_ind: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_SUMMARY) |=>
            ((tx_pend & $past(tx_pend)) == $past(tx_pend)) &&
            ((rx_pend & $past(rx_pend)) == $past(rx_pend)));

endmodule

// File: tb/irq_summary_unit_tb_top.sv
module irq_summary_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       rd_stb;
    logic [8:0] rd_addr;
    logic [7:0] rd_data;
    logic       sec_pulse;
    logic [7:0] tx_evt, rx_evt, tx_en, rx_en;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_summary_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .rd_stb_i   (rd_stb),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .sec_pulse_i(sec_pulse),
        .tx_evt_i   (tx_evt),
        .rx_evt_i   (rx_evt),
        .tx_en_i    (tx_en),
        .rx_en_i    (rx_en),
        .irq_o      (irq)
    );

    // {tx_fall, tx_en, rx_fall, rx_en, exp_tx, exp_rx, exp_summary}
    localparam logic [55:0] VEC [6] = '{
        {8'h01, 8'hFF, 8'h00, 8'hFF, 8'h01, 8'h00, 8'h02},
        {8'h00, 8'hFF, 8'h80, 8'hFF, 8'h00, 8'h80, 8'h01},
        {8'hF0, 8'h0F, 8'h0F, 8'h0F, 8'h00, 8'h0F, 8'h01},
        {8'hAA, 8'hFF, 8'h55, 8'hF0, 8'hAA, 8'h50, 8'h03},
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'h3C, 8'h3C, 8'hC3, 8'hC3, 8'h3C, 8'hC3, 8'h03}
    };

    function automatic logic [8:0] mk_addr(int port, logic [5:0] off);
        return {3'(port), off};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic rd(logic [8:0] a, output logic [7:0] d);
        rd_addr = a;
        rd_stb  = 1'b1;
        @(negedge clk);
        rd_stb  = 1'b0;
        d       = rd_data;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; rd_stb = 1'b0; rd_addr = '0;
        sec_pulse = 1'b1;
        tx_evt = 8'hFF; rx_evt = 8'hFF; tx_en = 8'hFF; rx_en = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();

        // R11: reset state; high idle pins create nothing
        check("R11 rd_data after reset", rd_data, 8'h00);
        check("R11 irq after reset", {7'b0, irq}, 8'h00);
        rd(mk_addr(0, 6'h00), d);
        check("R11 R1 summary after reset", d, 8'h00);
        sec_pulse = 1'b0;
        settle();

        // Vector walk: R1 R5 R6 R7 R10
        for (int v = 0; v < 6; v++) begin
            tx_en  = VEC[v][47:40];
            rx_en  = VEC[v][31:24];
            tx_evt = ~VEC[v][55:48];
            rx_evt = ~VEC[v][39:32];
            settle();
            check("R10 irq level", {7'b0, irq}, {7'b0, VEC[v][7:0] != 8'h00});
            rd(mk_addr(v % 8, 6'h00), d);
            check("R1 R7 summary word", d, VEC[v][7:0]);
            rd(mk_addr(v % 8, 6'h2C), d);
            check("R5 R6 tx indication", d, VEC[v][23:16]);
            rd(mk_addr(v % 8, 6'h2D), d);
            check("R5 R6 rx indication", d, VEC[v][15:8]);
            rd(mk_addr(v % 8, 6'h00), d);
            check("R7 summary cleared after reads", d, 8'h00);
            check("R10 irq low after reads", {7'b0, irq}, 8'h00);
            tx_evt = 8'hFF; rx_evt = 8'hFF;
            settle();
        end
        tx_en = 8'hFF; rx_en = 8'hFF;

        // R3 R4: one-second edge cleared via every port view
        for (int p = 0; p < 8; p++) begin
            sec_pulse = 1'b1;
            settle();
            check("R10 irq on one-second", {7'b0, irq}, 8'h01);
            rd(mk_addr(p, 6'h00), d);
            check("R3 one-second bit", d, 8'h08);
            rd(mk_addr(p, 6'h00), d);
            check("R4 one-second cleared by read", d, 8'h00);
            sec_pulse = 1'b0;
            settle();
        end

        // R8 R6 R2: summary read keeps indications; unmapped offset inert
        tx_evt = 8'hFE;
        settle();
        rd(mk_addr(3, 6'h00), d);
        check("R8 summary first read", d, 8'h02);
        rd(mk_addr(3, 6'h00), d);
        check("R8 summary second read", d, 8'h02);
        rd(mk_addr(3, 6'h2D), d);
        check("R6 rx read on empty rx", d, 8'h00);
        rd(mk_addr(3, 6'h10), d);
        check("R2 unmapped offset reads zero", d, 8'h00);
        @(negedge clk);
        check("R2 idle cycle data zero", rd_data, 8'h00);
        rd(mk_addr(3, 6'h00), d);
        check("R6 R2 tx still pending", d, 8'h02);
        rd(mk_addr(3, 6'h2C), d);
        check("R6 tx read", d, 8'h01);
        rd(mk_addr(3, 6'h00), d);
        check("R7 summary drops", d, 8'h00);
        tx_evt = 8'hFF;
        settle();

        // R5: edge while disabled is dropped, not deferred
        tx_en  = 8'h00;
        tx_evt = 8'hEF;
        settle();
        tx_en  = 8'hFF;
        settle();
        rd(mk_addr(1, 6'h2C), d);
        check("R5 disabled edge dropped", d, 8'h00);
        tx_evt = 8'hFF;
        settle();

        // R9: set and clearing read in the same edge
        tx_evt = 8'hFB;
        repeat (2) @(negedge clk);
        rd(mk_addr(2, 6'h2C), d);
        check("R9 colliding read returns old", d, 8'h00);
        rd(mk_addr(2, 6'h2C), d);
        check("R9 event survives clear", d, 8'h04);
        tx_evt = 8'hFF;
        settle();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule